// File: doc/BRIEF.md
# Serial Gray-Code Encoder on a Shift Register

This block turns a binary word into its reflected Gray code without any parallel XOR network. The word sits in a register that moves left by one place per clock. A single history bit holds the bit that last left the top of the register. On each active cycle, the top bit XORed with the history bit is fed back in at the bottom, and the history bit takes the old top bit.

After as many shift cycles as the word has bits, the register holds the Gray code of the original word. The generated bits appear in order from the most significant downward.

The block is used in three steps. Software-side logic writes a word through the parallel load port while the block is idle, then pulses start. It then waits for the one-cycle done pulse and reads the result from the parallel register output.

Top module: `gray_shift_enc`

## Requirements
- R1: A synchronous reset (rst high at a rising edge) clears the register output q, busy and done to zero.
- R2: When load is high while busy is low, the next edge copies load_data into q, clears the history bit and leaves busy low.
- R3: When start is high while busy and load are low, the next edge sets busy. That edge leaves q unchanged and clears the history bit.
- R4: On each edge with busy high, q shifts left by one. The new bit 0 is the old top bit XOR the history bit, and the history bit takes the old top bit. Because history starts at zero, the first bit produced equals the original top bit.
- R5: With W=8 and 8'hB7 loaded, q is 8'h7E after four shift edges: the upper half is the original low half, and the lower half is the Gray code of the original upper half.
- R6: After exactly W shift edges, q equals the Gray code of the loaded word, value ^ (value >> 1), and busy is low.
- R7: done is high for exactly one cycle, starting on the same edge at which busy falls, and is low at all other times.
- R8: A start pulse while busy is high has no effect on the result or on the cycle at which done appears.
- R9: A load pulse while busy is high has no effect on q or on the result.
- R10: If load and start are both high while idle, the load is taken and the start is ignored, so busy stays low.
- R11: While idle with no load, q holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock shared by the register and the history bit |
| rst | input | 1 | Synchronous active-high reset |
| load | input | 1 | Parallel load strobe, honoured only when idle |
| load_data | input | W | Word to be converted |
| start | input | 1 | Begins a conversion when idle |
| busy | output | 1 | High while shifts are in progress |
| done | output | 1 | One-cycle pulse when the Gray code is complete |
| q | output | W | Parallel contents of the shift register |

## Verification
The bench builds the encoder with its default width of 8. At this width the fixed 0xB7 halfway value can be checked, and all 256 input words can be swept in a short run, so every Gray pattern and every top-bit history sequence is produced. At this width the counter also wraps exactly at its final value, which tests termination at the limit of the counter's range.

// File: rtl/gray_shift_enc.sv
module gray_shift_enc #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_data,
  input  logic         start,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] q
);
  localparam int CW = (W > 1) ? $clog2(W) : 1;
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic          hist;
  logic [CW-1:0] cnt;
  logic          nbit;
  logic          take_load;
  logic          take_start;

  assign nbit       = q[W-1] ^ hist;
  assign take_load  = load & ~busy;
  assign take_start = start & ~busy & ~load;

  always_ff @(posedge clk) begin
    if (rst) begin
      q    <= '0;
      hist <= 1'b0;
      cnt  <= '0;
      busy <= 1'b0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (busy) begin
        q    <= {q[W-2:0], nbit};
        hist <= q[W-1];
        cnt  <= cnt + 1'b1;
        if (cnt == LAST) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end else if (take_load) begin
        q    <= load_data;
        hist <= 1'b0;
        cnt  <= '0;
      end else if (take_start) begin
        busy <= 1'b1;
        hist <= 1'b0;
        cnt  <= '0;
      end
    end
  end
endmodule

module gray_shift_enc_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         load,
  input logic [W-1:0] load_data,
  input logic         start,
  input logic         busy,
  input logic         done,
  input logic [W-1:0] q,
  input logic         hist
);
  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (q == '0 && !busy && !done));

  assert_idle_load_R2: assert property (@(posedge clk) disable iff (rst)
    (load && !busy) |=> (q == $past(load_data) && !busy && !hist));

  assert_start_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && !load) |=> (busy && $stable(q) && !hist));

  assert_shift_step_R4: assert property (@(posedge clk) disable iff (rst)
    busy |=> (q[W-1:1] == $past(q[W-2:0]) && q[0] == ($past(q[W-1]) ^ $past(hist))));

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_done_on_fall_R7: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);

  assert_done_not_busy_R7: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  assert_load_and_start_R10: assert property (@(posedge clk) disable iff (rst)
    (load && start && !busy) |=> !busy);

  assert_idle_hold_R11: assert property (@(posedge clk) disable iff (rst)
    (!busy && !load) |=> $stable(q));
endmodule

bind gray_shift_enc gray_shift_enc_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .load(load), .load_data(load_data), .start(start),
  .busy(busy), .done(done), .q(q), .hist(hist)
);

// File: tb/tb_gray_shift_enc.sv
`timescale 1ns/1ps
module tb_gray_shift_enc;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst;
  logic         load;
  logic [W-1:0] load_data;
  logic         start;
  logic         busy;
  logic         done;
  logic [W-1:0] q;

  int n_run  = 0;
  int n_fail = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  gray_shift_enc #(.W(W)) dut (
    .clk(clk), .rst(rst), .load(load), .load_data(load_data),
    .start(start), .busy(busy), .done(done), .q(q)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] gray(input logic [W-1:0] v);
    return v ^ (v >> 1);
  endfunction

  task automatic do_load(input logic [W-1:0] v);
    @(negedge clk); load = 1'b1; load_data = v;
    @(negedge clk); load = 1'b0;
  endtask

  task automatic do_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check(q == 0, "R1 q", int'(q), 0);
    check(!busy && !done, "R1 busy/done", int'({busy, done}), 0);
  endtask

  task automatic t_b7();
    do_load(8'hB7);
    check(q == 8'hB7 && !busy, "R2 load", int'(q), 'hB7);
    do_start();
    check(busy && q == 8'hB7, "R3 start", int'({busy, q}), int'({1'b1, 8'hB7}));
    @(negedge clk);
    check(q == 8'h6F, "R4 first bit = MSB", int'(q), 'h6F);
    repeat (3) @(negedge clk);
    check(q == 8'h7E, "R5 halfway", int'(q), 'h7E);
    repeat (3) @(negedge clk);
    check(busy && !done, "R7 not yet", int'({busy, done}), 2);
    @(negedge clk);
    check(q == gray(8'hB7), "R6 result", int'(q), int'(gray(8'hB7)));
    check(!busy && done, "R7 done rises", int'({busy, done}), 1);
    @(negedge clk);
    check(!done, "R7 done one cycle", int'(done), 0);
  endtask

  task automatic t_sweep();
    int bad = 0;
    for (int v = 0; v < 256; v++) begin
      do_load(W'(v));
      do_start();
      repeat (W) @(negedge clk);
      if (q != gray(W'(v)) || busy || !done) begin
        bad++;
        $display("FAIL R6 sweep v=%0h actual=%0h expected=%0h", v, q, gray(W'(v)));
      end
    end
    n_run++;
    if (bad != 0) n_fail++;
  endtask

  task automatic t_start_busy();
    do_load(8'h5A);
    do_start();
    repeat (2) @(negedge clk);
    start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (4) @(negedge clk);
    check(busy && !done, "R8 timing", int'({busy, done}), 2);
    @(negedge clk);
    check(q == gray(8'h5A) && done, "R8 result", int'(q), int'(gray(8'h5A)));
    @(negedge clk);
    check(!busy && !done, "R8 no restart", int'({busy, done}), 0);
  endtask

  task automatic t_load_busy();
    do_load(8'hC3);
    do_start();
    repeat (3) @(negedge clk);
    load = 1'b1; load_data = 8'h00;
    @(negedge clk); load = 1'b0;
    repeat (4) @(negedge clk);
    check(q == gray(8'hC3) && done, "R9 result", int'(q), int'(gray(8'hC3)));
  endtask

  task automatic t_both();
    @(negedge clk); load = 1'b1; start = 1'b1; load_data = 8'h96;
    @(negedge clk); load = 1'b0; start = 1'b0;
    check(q == 8'h96 && !busy, "R10 load wins", int'({busy, q}), 'h96);
    @(negedge clk);
    check(!busy && q == 8'h96, "R10 no start", int'({busy, q}), 'h96);
  endtask

  task automatic t_idle();
    do_load(8'h3C);
    repeat (5) @(negedge clk);
    check(q == 8'h3C && !busy && !done, "R11 hold", int'(q), 'h3C);
  endtask

  initial begin
    rst = 1'b1; load = 1'b0; start = 1'b0; load_data = '0;
    repeat (2) @(negedge clk);
    t_reset();
    t_b7();
    t_start_busy();
    t_load_busy();
    t_both();
    t_idle();
    t_sweep();
    do_load(8'hFF);
    t_reset();
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule